// File: doc/BRIEF.md
# UART Break Condition Detector

This block sits beside a UART receiver's deserializer. It watches each completed character and the receive line, and it decides when a break is in progress. A break is a character slot of the programmed length in which every data bit is zero and the stop-bit sample, taken at mid-stop by the receiver, is also zero. The first such character goes into the receive FIFO as one entry marked as a break. Every later character push is held back until the line has gone back to mark for half a bit time.

Break start and break end each produce a one-cycle change pulse for the interrupt logic. A sticky status flag stays set until software issues the error-reset command or the receiver is reset. The receive line passes through a synchronizer before the block samples it. Sample ticks come at 16x the bit rate, or at 1x in bypass mode.

Top module: `uart_brk_det`

## Requirements
- R1: A completed character is a break when its data bits [L-1:0] are all zero and its stop sample is 0. L is 5, 6, 7 or 8 for `len_sel_i` = 0, 1, 2 or 3, and data bits at or above L are ignored.
- R2: Outside a break, `char_done_i` drives `push_o` high in the same cycle. `push_break_o` is high with it exactly when that character is a break.
- R3: From the cycle after a break entry until break end, `push_o` stays low whatever `char_done_i` does. After the end it works normally again.
- R4: A break ends on the sample tick that completes a run of consecutive ticks with the synchronized line high. The run is OVERSAMPLE/2 ticks (8 by default) with `x1_mode_i`=0, or 2 ticks with `x1_mode_i`=1. A tick that sees the line low restarts the run.
- R5: `break_chg_o` is a one-cycle pulse in the cycle after the break entry, and again in the cycle after the tick that ends the break.
- R6: `break_o` goes high in the cycle after a break entry and holds.
- R7: When `cmd_valid_i` is high with `cmd_code_i`=4'h4, `break_o` clears on the next cycle and the push inhibit is left as it is. Other codes have no effect on `break_o`.
- R8: `rx_reset_i` clears `break_o`, `break_chg_o`, the inhibit and the marking count on the next edge.
- R9: `rx_i` passes through two flops. A change on it first counts toward a tick on the third clock edge after the change.
- R10: A break that begins in the middle of a character is reported on the next character. That first character is pushed as normal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick (16x or 1x) |
| x1_mode_i | input | 1 | 1 = ticks are at bit rate |
| rx_i | input | 1 | Asynchronous receive line |
| len_sel_i | input | 2 | Character length select (5 + value bits) |
| char_done_i | input | 1 | Receiver finished a character |
| char_data_i | input | DATA_W | Received data bits, bit 0 first received |
| char_stop_i | input | 1 | Stop-bit sample at mid-stop |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 4 | Command code |
| rx_reset_i | input | 1 | Synchronous receiver reset |
| push_o | output | 1 | Write the character into the FIFO |
| push_break_o | output | 1 | The pushed entry is a break |
| break_o | output | 1 | Sticky break status |
| break_chg_o | output | 1 | One-cycle change-in-break pulse |

## Verification
The bench places a single set bit just above and just below the programmed length. A detector that masks the wrong bits would then flag a break on a data character, or miss a real one. It interrupts the marking run with one low tick; a design that does not restart the count would end the break early. It ends a break in 1x mode with the tick starting together with the line rise, which shows both the synchronizer delay and the two-tick threshold. A missing flop would end the break one edge too soon. It also sends a nonzero character followed by an all-zero one, and checks that the error-reset command clears the flag while pushes stay held. A design that tied the inhibit to the flag would let characters into the FIFO during the break.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic {ST_IDLE, ST_BREAK} brk_state_e;
  localparam logic [3:0] CMD_ERR_RESET = 4'h4;
  localparam int unsigned MIN_CHAR_BITS = 5;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;  // idle line is mark
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/brk_char_chk.sv
module brk_char_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_BITS = 5
) (
  input  logic [1:0]        len_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  output logic              is_break_o
);
  logic [DATA_W-1:0] active;
  int unsigned       nbits;

  assign nbits = MIN_BITS + 32'(len_sel_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign active[i] = (32'(i) < nbits);
  end

  assign is_break_o = ~|(data_i & active) & ~stop_i;
endmodule

// File: rtl/brk_mark_timer.sv
module brk_mark_timer #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic line_i,
  input  logic x1_mode_i,
  output logic done_o
);
  localparam int unsigned HALF  = OVERSAMPLE / 2;
  localparam int unsigned CNT_W = $clog2(HALF) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = x1_mode_i ? CNT_W'(1) : CNT_W'(HALF - 1);
  assign done_o = tick_i & line_i & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i) begin
      if (!line_i || done_o)     cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_brk_det.sv
module uart_brk_det
  import uart_brk_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              x1_mode_i,
  input  logic              rx_i,
  input  logic [1:0]        len_sel_i,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_stop_i,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_code_i,
  input  logic              rx_reset_i,
  output logic              push_o,
  output logic              push_break_o,
  output logic              break_o,
  output logic              break_chg_o
);
  brk_state_e state_q;
  logic rx_s, char_brk, mark_done, in_brk, brk_end, err_clr;

  brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  brk_char_chk #(.DATA_W(DATA_W), .MIN_BITS(MIN_CHAR_BITS)) u_chk_char (
    .len_sel_i(len_sel_i), .data_i(char_data_i), .stop_i(char_stop_i),
    .is_break_o(char_brk)
  );

  assign in_brk = (state_q == ST_BREAK);

  brk_mark_timer #(.OVERSAMPLE(OVERSAMPLE)) u_mark (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(~in_brk | rx_reset_i),
    .tick_i(tick_i), .line_i(rx_s), .x1_mode_i(x1_mode_i), .done_o(mark_done)
  );

  assign push_o       = char_done_i & ~in_brk;
  assign push_break_o = push_o & char_brk;
  assign brk_end      = in_brk & mark_done;
  assign err_clr      = cmd_valid_i & (cmd_code_i == CMD_ERR_RESET);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      break_o     <= 1'b0;
      break_chg_o <= 1'b0;
    end else if (rx_reset_i) begin
      state_q     <= ST_IDLE;
      break_o     <= 1'b0;
      break_chg_o <= 1'b0;
    end else begin
      break_chg_o <= push_break_o | brk_end;
      if (push_break_o)  state_q <= ST_BREAK;
      else if (brk_end)  state_q <= ST_IDLE;
      if (push_break_o)  break_o <= 1'b1;  // set wins over clear
      else if (err_clr)  break_o <= 1'b0;
    end
endmodule

// File: rtl/uart_brk_det_chk.sv
module uart_brk_det_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_done_i,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_code_i,
  input logic              rx_reset_i,
  input logic              push_o,
  input logic              push_break_o,
  input logic              break_o,
  input logic              break_chg_o
);
  logic armed_q, pbrk_q, end_now;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pbrk_q  <= 1'b0;
    end else begin
      pbrk_q <= push_break_o & ~rx_reset_i;
      if (rx_reset_i)                     armed_q <= 1'b0;
      else if (push_break_o)              armed_q <= 1'b1;
      else if (break_chg_o && !pbrk_q)    armed_q <= 1'b0;
    end

  assign end_now = break_chg_o & ~pbrk_q;

  a_r2_brk_is_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_break_o |-> (push_o && char_done_i));
  a_r3_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !end_now) |-> !push_o);
  a_r5_chg_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_break_o && !rx_reset_i) |=> break_chg_o);
  a_r5_chg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_chg_o |-> (pbrk_q || armed_q));
  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_break_o && !rx_reset_i) |=> break_o);
  a_r7_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_code_i == 4'h4 && !push_break_o && !rx_reset_i) |=> !break_o);
  a_r8_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_i |=> (!break_o && !break_chg_o));
endmodule

bind uart_brk_det uart_brk_det_chk #(.DATA_W(DATA_W)) u_brk_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .char_done_i(char_done_i),
  .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .rx_reset_i(rx_reset_i),
  .push_o(push_o), .push_break_o(push_break_o), .break_o(break_o),
  .break_chg_o(break_chg_o)
);

// File: tb/sim_uart_brk_det.sv
`timescale 1ns/1ps
module sim_uart_brk_det;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, x1_mode_i = 0, rx_i = 1;
  logic [1:0] len_sel_i = 0;
  logic char_done_i = 0, char_stop_i = 1;
  logic [7:0] char_data_i = 0;
  logic cmd_valid_i = 0, rx_reset_i = 0;
  logic [3:0] cmd_code_i = 0;
  logic push_o, push_break_o, break_o, break_chg_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  uart_brk_det u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .x1_mode_i(x1_mode_i),
    .rx_i(rx_i), .len_sel_i(len_sel_i), .char_done_i(char_done_i),
    .char_data_i(char_data_i), .char_stop_i(char_stop_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .rx_reset_i(rx_reset_i),
    .push_o(push_o), .push_break_o(push_break_o), .break_o(break_o),
    .break_chg_o(break_chg_o)
  );

  // {len_sel, data, stop, exp_push, exp_brk}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 8'h00, 1'b0, 1'b1, 1'b1},
    {2'd0, 8'hE0, 1'b0, 1'b1, 1'b1},
    {2'd0, 8'h01, 1'b0, 1'b1, 1'b0},
    {2'd0, 8'h00, 1'b1, 1'b1, 1'b0},
    {2'd1, 8'h20, 1'b0, 1'b1, 1'b0},
    {2'd1, 8'hC0, 1'b0, 1'b1, 1'b1},
    {2'd2, 8'h40, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h80, 1'b0, 1'b1, 1'b1},
    {2'd3, 8'h80, 1'b0, 1'b1, 1'b0},
    {2'd3, 8'h00, 1'b0, 1'b1, 1'b1},
    {2'd3, 8'h00, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // present a character for one cycle; returns combinational push outputs
  task automatic send_char(input logic [1:0] len, input logic [7:0] d,
                           input logic stp, output logic p, output logic pb);
    len_sel_i = len; char_data_i = d; char_stop_i = stp; char_done_i = 1'b1;
    #1; p = push_o; pb = push_break_o;
    @(negedge clk);
    char_done_i = 1'b0; char_stop_i = 1'b1;
  endtask

  task automatic do_rx_reset();
    rx_reset_i = 1'b1; @(negedge clk); rx_reset_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic p, pb;
    cyc(3); rst_ni = 1'b1; cyc(1);
    chk("R6 reset break_o", break_o, 0);
    chk("R5 reset break_chg_o", break_chg_o, 0);
    chk("R2 reset push_o", push_o, 0);

    // R1/R2 table walk, line held low so no break ends
    rx_i = 1'b0; cyc(3);
    for (int v = 0; v < NV; v++) begin
      send_char(VEC[v][12:11], VEC[v][10:3], VEC[v][2], p, pb);
      chk($sformatf("R1/R2 vec%0d push", v), p, int'(VEC[v][1]));
      chk($sformatf("R1 vec%0d brk", v), pb, int'(VEC[v][0]));
      if (VEC[v][0]) do_rx_reset();
    end

    // detection, flag, change pulse
    send_char(2'd3, 8'h00, 1'b0, p, pb);
    chk("R2 entry push_break", pb, 1);
    chk("R5 chg after entry", break_chg_o, 1);
    chk("R6 flag set", break_o, 1);
    cyc(1);
    chk("R5 chg single cycle", break_chg_o, 0);
    send_char(2'd3, 8'h41, 1'b1, p, pb);
    chk("R3 push held in break", p, 0);

    // R7 command handling
    cmd_valid_i = 1'b1; cmd_code_i = 4'h3; @(negedge clk); cmd_valid_i = 1'b0;
    chk("R7 other code ignored", break_o, 1);
    cmd_valid_i = 1'b1; cmd_code_i = 4'h4; @(negedge clk); cmd_valid_i = 1'b0;
    chk("R7 err reset clears", break_o, 0);
    send_char(2'd3, 8'h41, 1'b1, p, pb);
    chk("R7 inhibit kept", p, 0);

    // R4 end at 16x with a restart
    rx_i = 1'b1; cyc(3); ticks(5);
    rx_i = 1'b0; cyc(3); ticks(1);
    rx_i = 1'b1; cyc(3); ticks(7);
    chk("R4 no end after 7 ticks", break_chg_o, 0);
    send_char(2'd3, 8'h41, 1'b1, p, pb);
    chk("R4 still inhibited", p, 0);
    ticks(1);
    chk("R4/R5 chg at end", break_chg_o, 1);
    cyc(1);
    chk("R5 end chg single", break_chg_o, 0);
    send_char(2'd3, 8'h41, 1'b1, p, pb);
    chk("R3 push released", p, 1);

    // R9 synchronizer delay, 1x mode
    rx_i = 1'b0; cyc(3);
    send_char(2'd0, 8'h00, 1'b0, p, pb);
    chk("R1 5-bit break", pb, 1);
    x1_mode_i = 1'b1; cyc(1);
    rx_i = 1'b1; ticks(3);
    chk("R9 line not yet seen", break_chg_o, 0);
    ticks(1);
    chk("R9/R4 1x end", break_chg_o, 1);
    x1_mode_i = 1'b0; cyc(1);

    // R8 receiver reset
    rx_i = 1'b0; cyc(3);
    send_char(2'd3, 8'h00, 1'b0, p, pb);
    do_rx_reset();
    chk("R8 flag cleared", break_o, 0);
    chk("R8 chg cleared", break_chg_o, 0);
    send_char(2'd3, 8'h41, 1'b1, p, pb);
    chk("R8 inhibit cleared", p, 1);

    // R10 break starting mid-character
    send_char(2'd3, 8'h1C, 1'b0, p, pb);
    chk("R10 first char pushed", p, 1);
    chk("R10 first char not break", pb, 0);
    send_char(2'd3, 8'h00, 1'b0, p, pb);
    chk("R10 next char break", pb, 1);
    do_rx_reset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule